// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames. A host writes bytes into a one-entry holding register, and the block sends each one as a frame on a single output line. The line is high when idle. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period. One line control byte sets the frame shape. The same byte has a bit that holds the line low (break) and a bit that swaps two register offsets over to a 16-bit clock divisor.

The divisor sets the length of one tick. Each data bit lasts 16 ticks. A new frame starts only on a tick. When the next byte is already waiting as a frame's stop period ends, it follows at once with no idle gap. Two status outputs tell the host when it may write another byte and when the line has fully drained.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is high and both `thr_empty` and `tx_empty` are 1.
- R2: A frame is one low start bit, then the data bits least significant bit first. The data width is set by line control bits [1:0]: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: Line control bit 3 adds a parity bit after the data. When bit 4 is 1 the parity bit makes the count of ones in data plus parity even. When bit 4 is 0 the count is odd.
- R4: When line control bits 3 and 5 are both set, the parity bit is a constant: 0 if bit 4 is 1, and 1 if bit 4 is 0.
- R5: The stop period is high. It lasts 16 ticks when line control bit 2 is 0. When bit 2 is 1 it lasts 32 ticks, or 24 ticks when the data width is 5.
- R6: One tick is D clock cycles, where D is the 16-bit divisor (0 means 65536), so a bit lasts 16·D cycles. A frame starts on a tick. A byte that is already waiting when a stop period ends starts exactly at the end of that stop period.
- R7: While line control bit 6 is 1, `txd` is low, whatever the transmitter state.
- R8: Writes to offset 3 load the line control byte.
  - When line control bit 7 is 1, writes to offsets 0 and 1 load the divisor low and high bytes, and offset 0 does not reach the holding register. Each divisor write also restarts the tick counter.
  - When bit 7 is 0, a write to offset 0 fills the holding register and a write to offset 1 has no effect.
- R9: `thr_empty` goes to 0 in the cycle after a holding write. It returns to 1 when the byte moves into the shifter. `tx_empty` is 1 only when the holding register is empty and no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data byte |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
Status flags settle one clock after the write edge, so the bench reads them at the falling edge that follows each write.

Serial bits come from a tick-aligned state machine, so every bit has a fixed cycle window once the start edge is seen:
- The monitor takes the start-edge cycle as time zero.
- It samples bit k at the middle of its window, 16·D·k + 8·D cycles later.
- For bursts it checks that the next start edge falls exactly one frame length after the previous one. That frame length is worked out in the bench from the line control byte, and this is the check that measures the 1.5 and 2 stop-bit periods.

The divisor-zero case is checked on either side of the first tick, 65536 cycles after the divisor write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wsel;       // data width code, 0..3 -> 5..8 bits
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  function automatic int data_bits(logic [1:0] wsel);
    return 5 + int'(wsel);
  endfunction

  // Parity bit for a byte under a given frame shape
  function automatic logic calc_parity(frame_cfg_t c, logic [7:0] d);
    logic [7:0] mask;
    logic       ones;
    mask = 8'hFF >> (3 - int'(c.wsel));
    ones = ^(d & mask);
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? ones : ~ones;
  endfunction

  // Stop period length in ticks
  function automatic int stop_ticks(frame_cfg_t c, int osr);
    if (!c.two_stop) return osr;
    if (c.wsel == 2'd0) return osr + osr / 2;
    return 2 * osr;
  endfunction

endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs #(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        lcr,
  output logic [DIV_W-1:0]  divisor,
  output logic              div_wr,
  output logic              hold_wr
);
  localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_LCR = ADDR_W'(3);
  localparam int               HI_W    = DIV_W - 8;

  logic dlab;
  assign dlab    = lcr[7];
  assign hold_wr = wr_en && (wr_addr == OFS_LO) && !dlab;
  assign div_wr  = wr_en && dlab && ((wr_addr == OFS_LO) || (wr_addr == OFS_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr     <= 8'h00;
      divisor <= DIV_W'(1);
    end else if (wr_en) begin
      if (wr_addr == OFS_LCR) lcr <= wr_data;
      if (dlab && wr_addr == OFS_LO) divisor[7:0] <= wr_data;
      if (dlab && wr_addr == OFS_HI) divisor[DIV_W-1:8] <= wr_data[HI_W-1:0];
    end
  end

  // R8: a divisor write never fills the holding register
  a_r8_dlab_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> !hold_wr);

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             div_wr,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // divisor 0 wraps to all ones, which gives a period of 2**DIV_W
  assign lim  = divisor - DIV_W'(1);
  assign tick = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (div_wr)     cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  // R6: ticks are isolated unless the divisor is 1
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && !div_wr) |=> !tick);

  // R8: a divisor write restarts the count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (cnt == '0));

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold_wr,
  input  logic [7:0] hold_data,
  input  frame_cfg_t cfg,
  input  logic       brk,
  output logic       txd,
  output logic       thr_empty,
  output logic       tx_empty
);
  localparam int TCNT_W = $clog2(2 * OSR + 1);

  tx_state_e          state;
  logic [7:0]         thr_q;
  logic               thr_full;
  logic [7:0]         shreg;
  frame_cfg_t         cfg_q;
  logic [2:0]         bit_idx;
  logic [TCNT_W-1:0]  tcnt;
  logic               par_q;

  logic [TCNT_W-1:0]  cur_len;
  logic               bit_end;
  logic               last_data;
  logic               load_evt;
  logic               line;

  assign cur_len   = (state == ST_STOP) ? TCNT_W'(stop_ticks(cfg_q, OSR)) : TCNT_W'(OSR);
  assign bit_end   = tick && (tcnt == cur_len - TCNT_W'(1));
  assign last_data = (bit_idx == 3'(data_bits(cfg_q.wsel) - 1));
  assign load_evt  = thr_full && tick &&
                     ((state == ST_IDLE) || (state == ST_STOP && bit_end));

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign txd       = brk ? 1'b0 : line;
  assign thr_empty = !thr_full;
  assign tx_empty  = !thr_full && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '0;
      thr_full <= 1'b0;
    end else begin
      if (load_evt) thr_full <= 1'b0;
      if (hold_wr) begin
        thr_q    <= hold_data;
        thr_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      cfg_q   <= '0;
      bit_idx <= '0;
      tcnt    <= '0;
      par_q   <= 1'b0;
    end else if (load_evt) begin
      state   <= ST_START;
      shreg   <= thr_q;
      cfg_q   <= cfg;
      par_q   <= calc_parity(cfg, thr_q);
      bit_idx <= '0;
      tcnt    <= '0;
    end else if (bit_end) begin
      tcnt <= '0;
      case (state)
        ST_START: begin
          state   <= ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA: begin
          shreg <= shreg >> 1;
          if (last_data) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else           bit_idx <= bit_idx + 3'd1;
        end
        ST_PAR:  state <= ST_STOP;
        default: state <= ST_IDLE;
      endcase
    end else if (tick && state != ST_IDLE) begin
      tcnt <= tcnt + TCNT_W'(1);
    end
  end

  // R9: idle flag implies holding flag
  a_r9_empty_implies_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

  // R9: a holding write is seen as full next cycle
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !thr_empty);

  // R2: a load begins with the start bit on the line
  a_r2_load_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (line == 1'b0));

  // R6: the sequencer only moves on ticks
  a_r6_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !$isunknown(state)) |=> $stable(state));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_empty
);
  logic [7:0]       lcr;
  logic [DIV_W-1:0] divisor;
  logic             div_wr;
  logic             hold_wr;
  logic             tick;
  frame_cfg_t       cfg;

  assign cfg.wsel      = lcr[1:0];
  assign cfg.two_stop  = lcr[2];
  assign cfg.par_en    = lcr[3];
  assign cfg.par_even  = lcr[4];
  assign cfg.par_stick = lcr[5];

  uart_cfg_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lcr(lcr), .divisor(divisor), .div_wr(div_wr), .hold_wr(hold_wr)
  );

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_wr(div_wr), .tick(tick)
  );

  uart_tx_engine #(.OSR(OSR)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_wr(hold_wr), .hold_data(wr_data),
    .cfg(cfg), .brk(lcr[6]), .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  // R7: break bit in the register holds the line low
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    lcr[6] |-> !txd);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] lcr;
    logic       chained;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       txd, thr_empty, tx_empty;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int div_v    = 2;
  bit mon_en   = 1'b0;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // driver: pushes the expected frame, then writes the byte
  task automatic send(logic [7:0] d, logic [7:0] lcr_v, bit chained);
    exp_item_t it;
    while (!thr_empty) @(negedge clk);
    it.data = d; it.lcr = lcr_v; it.chained = chained;
    sb_q.push_back(it);
    reg_write(3'd0, d);
    check("R9 thr_empty after write", int'(thr_empty), 0);
    check("R9 tx_empty after write", int'(tx_empty), 0);
  endtask

  task automatic burst(logic [7:0] lcr_v, logic [7:0] b0, logic [7:0] b1, int n);
    wait_idle();
    check("R9 both flags idle", int'(thr_empty), 1);
    reg_write(3'd3, lcr_v);
    send(b0, lcr_v, 1'b0);
    if (n > 1) send(b1, lcr_v, 1'b1);
    wait_idle();
  endtask

  // monitor: pops expected frames and samples each bit in its window
  initial begin : monitor
    int prev_t0 = 0;
    int prev_len = 0;
    forever begin
      @(negedge clk);
      if (mon_en && txd == 1'b0) begin
        int t0, wl, nb, bp, stopt, ones;
        bit pen;
        logic [7:0] got, want;
        exp_item_t it;
        t0 = cyc;
        if (sb_q.size() == 0) begin
          check("R2 unexpected frame", 1, 0);
          continue;
        end
        it = sb_q.pop_front();
        wl = 5 + int'(it.lcr[1:0]);
        pen = it.lcr[3];
        bp = 16 * div_v;
        if (it.chained) check("R6/R5 back-to-back start spacing", t0 - prev_t0, prev_len);
        wait_until(t0 + bp / 2);
        check("R2 start bit low", int'(txd), 0);
        got = '0;
        for (int k = 0; k < wl; k++) begin
          wait_until(t0 + bp * (k + 1) + bp / 2);
          got[k] = txd;
        end
        want = it.data & (8'hFF >> (8 - wl));
        check("R2 data bits", int'(got), int'(want));
        if (pen) begin
          int pexp;
          ones = 0;
          for (int k = 0; k < wl; k++) ones += int'(want[k]);
          if (it.lcr[5]) pexp = it.lcr[4] ? 0 : 1;
          else           pexp = it.lcr[4] ? (ones % 2) : 1 - (ones % 2);
          wait_until(t0 + bp * (wl + 1) + bp / 2);
          if (it.lcr[5]) check("R4 stick parity bit", int'(txd), pexp);
          else           check("R3 parity bit", int'(txd), pexp);
        end
        nb = 1 + wl + (pen ? 1 : 0);
        wait_until(t0 + bp * nb + bp / 2);
        check("R5 stop level high", int'(txd), 1);
        stopt = it.lcr[2] ? ((wl == 5) ? 24 : 32) : 16;
        prev_t0 = t0;
        prev_len = nb * bp + stopt * div_v;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 txd idle high", int'(txd), 1);
    check("R1 thr_empty reset", int'(thr_empty), 1);
    check("R1 tx_empty reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // divisor = 2 through the access window
    reg_write(3'd3, 8'h80);
    reg_write(3'd0, 8'h02);
    check("R8 divisor write keeps holding empty", int'(thr_empty), 1);
    reg_write(3'd1, 8'h00);
    reg_write(3'd3, 8'h03);
    repeat (100) @(negedge clk);
    check("R8 no frame from divisor write", int'(txd), 1);
    // offset 1 with access bit clear must not touch the divisor
    reg_write(3'd1, 8'hFF);
    mon_en = 1'b1;

    burst(8'h03, 8'hA5, 8'h3C, 2);  // 8 bits, 1 stop
    burst(8'h1B, 8'h01, 8'h7F, 2);  // 8 bits, even parity
    burst(8'h0B, 8'h55, 8'h80, 2);  // 8 bits, odd parity
    burst(8'h3A, 8'h2B, 8'h7F, 2);  // 7 bits, stick even -> 0
    burst(8'h2A, 8'h11, 8'h00, 2);  // 7 bits, stick odd -> 1
    burst(8'h0C, 8'h15, 8'h0A, 2);  // 5 bits, 1.5 stop, parity odd
    burst(8'h05, 8'h2D, 8'h12, 2);  // 6 bits, 2 stop
    burst(8'h1F, 8'hC3, 8'h00, 2);  // 8 bits, 2 stop, even parity
    check("R2 all frames seen", sb_q.size(), 0);

    // break
    mon_en = 1'b0;
    reg_write(3'd3, 8'h43);
    check("R7 break drives low", int'(txd), 0);
    repeat (50) @(negedge clk);
    check("R7 break held low", int'(txd), 0);
    reg_write(3'd3, 8'h03);
    check("R7 break released", int'(txd), 1);

    // divisor zero -> 65536
    begin
      int t_div;
      reg_write(3'd3, 8'h80);
      reg_write(3'd0, 8'h00);
      reg_write(3'd1, 8'h00);
      t_div = cyc;
      reg_write(3'd3, 8'h03);
      reg_write(3'd0, 8'h00);
      wait_until(t_div + 60000);
      check("R6 div0 no start before 65536", int'(txd), 1);
      check("R9 byte still held", int'(thr_empty), 0);
      wait_until(t_div + 66000);
      check("R6 div0 start after 65536", int'(txd), 0);
      check("R9 byte moved to shifter", int'(thr_empty), 1);
      check("R9 tx busy during frame", int'(tx_empty), 0);
    end

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 txd after reset", int'(txd), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule